// File: doc/BRIEF.md
# Paced Ethernet Byte Sideband Port

This block sits at the link end of a byte-wide Ethernet side channel that travels inside a framed radio link. On the user side it has an AXI4-Stream slave for transmit bytes and an AXI4-Stream master for received bytes. Both carry 8-bit data with tlast and tuser flags. On the link side it hands each accepted byte to the framer and takes recovered bytes back from it.

Bytes never move continuously. A cycle is an open "slot" only while the current subchannel index from the framer is at or above a static Ethernet pointer. Within that run of cycles, slots recur at a fixed period: 5 cycles in the narrow datapath modes and 2 cycles in the wide mode. The pacing count restarts on the first cycle of each region visit, so the first slot falls on that cycle. Transmit bytes are accepted only in slots. Each accepted byte appears on the link outputs one cycle later. A byte arriving from the link is held in a one-byte holding stage and is released to the receive master after the next slot.

Top module: `eth_sideband_port`

## Requirements
- R1: While `rst` is high, `tx_tready`, `link_tx_valid` and `rx_tvalid` are low, and all pacing state clears.
- R2: A cycle can be a slot only when `eth_ptr` <= LAST_SUBCH and `subch_idx` >= `eth_ptr`. `tx_tready` is high exactly in slot cycles.
- R3: The first cycle of each visit to the region is a slot. Further slots follow every 5 cycles when `wide_mode`=0 and every 2 cycles when `wide_mode`=1, as long as the region lasts.
- R4: A byte is accepted on a cycle with `tx_tvalid` and `tx_tready` both high. In the next cycle `link_tx_valid` is high for one cycle with `link_tx_data`, `link_tx_last` and `link_tx_err` equal to that byte's `tx_tdata`, `tx_tlast` and `tx_tuser`.
- R5: A byte taken from the link (`link_rx_valid` high) is released after the next slot that comes after its arrival. `rx_tvalid` rises only in the cycle right after a slot and is a single-cycle pulse.
- R6: Bytes come out of the receive master in link order, with `rx_tlast` on exactly the bytes that carried it. Back-to-back frames with no idle slot between them stay intact.
- R7: `rx_tuser` repeats the error flag carried with each byte, so a `tx_tuser` mark survives a loopback onto the same byte.
- R8: When `eth_ptr` > LAST_SUBCH the channel is disabled. `tx_tready` stays low whatever `tx_tvalid` does, and no byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 = wide datapath (period 2), 0 = narrow (period 5); static |
| eth_ptr | input | SUBCH_W | First subchannel of the Ethernet region; static |
| subch_idx | input | SUBCH_W | Current subchannel from the framer |
| tx_tdata | input | 8 | Transmit byte |
| tx_tvalid | input | 1 | Transmit byte present |
| tx_tlast | input | 1 | Final byte of a frame |
| tx_tuser | input | 1 | Send an error code with this byte |
| tx_tready | output | 1 | Slot open; byte taken when tx_tvalid is high |
| link_tx_valid | output | 1 | Byte handed to the framer this cycle |
| link_tx_data | output | 8 | Byte to the framer |
| link_tx_last | output | 1 | Frame end flag to the framer |
| link_tx_err | output | 1 | Error flag to the framer |
| link_rx_valid | input | 1 | Recovered byte from the framer |
| link_rx_data | input | 8 | Recovered byte |
| link_rx_last | input | 1 | Recovered frame end flag |
| link_rx_err | input | 1 | Recovered error flag |
| rx_tdata | output | 8 | Received byte |
| rx_tvalid | output | 1 | Single-cycle byte strobe, no back-pressure |
| rx_tlast | output | 1 | Final byte of a received frame |
| rx_tuser | output | 1 | Received byte carried an error code |

## Verification
The bench keeps its own count of cycles since each region entry and compares `tx_tready` with it on every cycle. It does this in both modes, with the region covering part of the frame and with it covering the whole frame. A design that does not restart the count at entry, or uses the wrong period, shows a shifted or wrongly spaced `tx_tready` at once. Frames of random length with random error flags, sent back to back through a loopback, catch holding-stage losses, order swaps and flags moved to the wrong byte as mismatches against the accepted-byte queue. A pointer past the last subchannel, with `tx_tvalid` held high, catches a region compare that wraps or ignores the enable.

// File: rtl/eth_sb_pkg.sv
package eth_sb_pkg;

    // One sideband byte with its qualifiers.
    typedef struct packed {
        logic [7:0] data;
        logic       last;
        logic       err;
    } sb_byte_t;

    // Byte plus a presence flag, used for staged registers.
    typedef struct packed {
        logic     valid;
        sb_byte_t pay;
    } sb_slot_t;

endpackage

// File: rtl/eth_slot_pacer.sv
module eth_slot_pacer #(
    parameter int SUBCH_W       = 4,
    parameter int LAST_SUBCH    = 11,
    parameter int NARROW_PERIOD = 5,
    parameter int WIDE_PERIOD   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wide_mode,
    input  logic [SUBCH_W-1:0] eth_ptr,
    input  logic [SUBCH_W-1:0] subch_idx,
    output logic               slot
);
    localparam int MAX_P = (NARROW_PERIOD > WIDE_PERIOD) ? NARROW_PERIOD : WIDE_PERIOD;
    localparam int CNT_W = $clog2(MAX_P + 1);
    localparam logic [SUBCH_W-1:0] LAST_L = SUBCH_W'(LAST_SUBCH);
    localparam logic [CNT_W-1:0]   P_NAR  = CNT_W'(NARROW_PERIOD);
    localparam logic [CNT_W-1:0]   P_WID  = CNT_W'(WIDE_PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             was_in;
    } pacer_t;

    pacer_t           st_q, st_d;
    logic             in_region;
    logic             enabled;
    logic             entry;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt_eff;

    always_comb begin
        period    = wide_mode ? P_WID : P_NAR;
        enabled   = (eth_ptr <= LAST_L);
        in_region = enabled && (subch_idx >= eth_ptr);
        entry     = in_region && !st_q.was_in;
        cnt_eff   = (entry || (st_q.cnt >= period)) ? '0 : st_q.cnt;
        slot      = !rst && in_region && (cnt_eff == '0);

        st_d        = st_q;
        st_d.was_in = in_region;
        if (!in_region) begin
            st_d.cnt = '0;
        end else if (cnt_eff == period - 1'b1) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_eff + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the first cycle of a region visit is always a slot
    a_r3_entry_slot: assert property (@(posedge clk) disable iff (rst)
        (in_region && !st_q.was_in) |-> slot);

    // R3: slots are never adjacent (period is at least two)
    a_r3_no_adjacent: assert property (@(posedge clk) disable iff (rst)
        slot |=> !slot);

    // R2 / R8: no slot outside the region or with the pointer out of range
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        ((eth_ptr > LAST_L) || (subch_idx < eth_ptr)) |-> !slot);

endmodule

// File: rtl/eth_tx_lane.sv
module eth_tx_lane
    import eth_sb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       slot,
    input  logic [7:0] tx_tdata,
    input  logic       tx_tvalid,
    input  logic       tx_tlast,
    input  logic       tx_tuser,
    output logic       tx_tready,
    output sb_slot_t   link_out
);
    sb_slot_t out_q, out_d;

    always_comb begin
        tx_tready      = slot;
        out_d          = out_q;
        out_d.valid    = slot && tx_tvalid;
        if (slot && tx_tvalid) begin
            out_d.pay.data = tx_tdata;
            out_d.pay.last = tx_tlast;
            out_d.pay.err  = tx_tuser;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign link_out = out_q;

    // R4: an accepted byte appears on the link one cycle later, unchanged
    a_r4_link_follows: assert property (@(posedge clk) disable iff (rst)
        (tx_tvalid && tx_tready) |=>
        (link_out.valid && link_out.pay.data == $past(tx_tdata)
         && link_out.pay.last == $past(tx_tlast) && link_out.pay.err == $past(tx_tuser)));

    // R4: nothing reaches the link without a handshake
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(tx_tvalid && tx_tready) |=> !link_out.valid);

endmodule

// File: rtl/eth_rx_lane.sv
module eth_rx_lane
    import eth_sb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     slot,
    input  sb_slot_t link_in,
    output sb_slot_t rx_out
);
    typedef struct packed {
        sb_slot_t hold;
        sb_slot_t out;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic      drain;

    always_comb begin
        drain         = slot && st_q.hold.valid;
        st_d          = st_q;
        st_d.out.valid = drain;
        if (drain) begin
            st_d.out.pay = st_q.hold.pay;
        end
        if (link_in.valid) begin
            st_d.hold = link_in;
        end else if (drain) begin
            st_d.hold.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_out = st_q.out;

    // R5: receive strobe is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_out.valid |=> !rx_out.valid);

    // R5: receive strobe only follows a slot
    a_r5_after_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_out.valid) |-> $past(slot));

endmodule

// File: rtl/eth_sideband_port.sv
module eth_sideband_port
    import eth_sb_pkg::*;
#(
    parameter int SUBCH_W       = 4,
    parameter int LAST_SUBCH    = 11,
    parameter int NARROW_PERIOD = 5,
    parameter int WIDE_PERIOD   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wide_mode,
    input  logic [SUBCH_W-1:0] eth_ptr,
    input  logic [SUBCH_W-1:0] subch_idx,
    input  logic [7:0]         tx_tdata,
    input  logic               tx_tvalid,
    input  logic               tx_tlast,
    input  logic               tx_tuser,
    output logic               tx_tready,
    output logic               link_tx_valid,
    output logic [7:0]         link_tx_data,
    output logic               link_tx_last,
    output logic               link_tx_err,
    input  logic               link_rx_valid,
    input  logic [7:0]         link_rx_data,
    input  logic               link_rx_last,
    input  logic               link_rx_err,
    output logic [7:0]         rx_tdata,
    output logic               rx_tvalid,
    output logic               rx_tlast,
    output logic               rx_tuser
);
    logic     slot;
    sb_slot_t link_out;
    sb_slot_t link_in;
    sb_slot_t rx_out;

    eth_slot_pacer #(
        .SUBCH_W      (SUBCH_W),
        .LAST_SUBCH   (LAST_SUBCH),
        .NARROW_PERIOD(NARROW_PERIOD),
        .WIDE_PERIOD  (WIDE_PERIOD)
    ) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .wide_mode(wide_mode),
        .eth_ptr  (eth_ptr),
        .subch_idx(subch_idx),
        .slot     (slot)
    );

    eth_tx_lane u_tx (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot),
        .tx_tdata (tx_tdata),
        .tx_tvalid(tx_tvalid),
        .tx_tlast (tx_tlast),
        .tx_tuser (tx_tuser),
        .tx_tready(tx_tready),
        .link_out (link_out)
    );

    always_comb begin
        link_in.valid    = link_rx_valid;
        link_in.pay.data = link_rx_data;
        link_in.pay.last = link_rx_last;
        link_in.pay.err  = link_rx_err;
    end

    eth_rx_lane u_rx (
        .clk    (clk),
        .rst    (rst),
        .slot   (slot),
        .link_in(link_in),
        .rx_out (rx_out)
    );

    assign link_tx_valid = link_out.valid;
    assign link_tx_data  = link_out.pay.data;
    assign link_tx_last  = link_out.pay.last;
    assign link_tx_err   = link_out.pay.err;
    assign rx_tvalid     = rx_out.valid;
    assign rx_tdata      = rx_out.pay.data;
    assign rx_tlast      = rx_out.pay.last;
    assign rx_tuser      = rx_out.pay.err;

    // R1: outputs quiet in the cycle after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rx_tvalid && !link_tx_valid));

    // R1: ready held low during reset
    always_comb begin
        if (rst === 1'b1) begin
            a_r1_ready_low: assert (!tx_tready);
        end
    end

endmodule

// File: tb/eth_sideband_port_test.sv
module eth_sideband_port_test;
    localparam int SW      = 4;
    localparam int LAST    = 11;
    localparam int SUB_CYC = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wide_mode = 1'b0;
    logic [SW-1:0] eth_ptr = 4'd8;
    logic [SW-1:0] subch_idx = '0;
    logic [7:0]    tx_tdata = '0;
    logic          tx_tvalid = 1'b0, tx_tlast = 1'b0, tx_tuser = 1'b0;
    logic          tx_tready;
    logic          link_tx_valid, link_tx_last, link_tx_err;
    logic [7:0]    link_tx_data;
    logic [7:0]    rx_tdata;
    logic          rx_tvalid, rx_tlast, rx_tuser;

    int n_checks = 0;
    int n_fail   = 0;
    int sent     = 0;
    int got      = 0;
    int sub_cnt  = 0;
    logic [9:0] exp_q[$];

    always #10 clk = ~clk;

    eth_sideband_port #(.SUBCH_W(SW), .LAST_SUBCH(LAST)) uut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .eth_ptr(eth_ptr),
        .subch_idx(subch_idx),
        .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tlast(tx_tlast),
        .tx_tuser(tx_tuser), .tx_tready(tx_tready),
        .link_tx_valid(link_tx_valid), .link_tx_data(link_tx_data),
        .link_tx_last(link_tx_last), .link_tx_err(link_tx_err),
        .link_rx_valid(link_tx_valid), .link_rx_data(link_tx_data),
        .link_rx_last(link_tx_last), .link_rx_err(link_tx_err),
        .rx_tdata(rx_tdata), .rx_tvalid(rx_tvalid), .rx_tlast(rx_tlast),
        .rx_tuser(rx_tuser)
    );

    // Framer stub: SUB_CYC cycles per subchannel, 0..LAST
    always @(posedge clk) begin
        if (sub_cnt == SUB_CYC - 1) begin
            sub_cnt <= 0;
            subch_idx <= (subch_idx == SW'(LAST)) ? '0 : subch_idx + 1'b1;
        end else begin
            sub_cnt <= sub_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle monitor: independent slot model and receive comparison
    int   k = 0;
    bit   prev_in = 0, prev_exp = 0, prev_acc = 0;
    logic [9:0] prev_byte = '0;
    always @(negedge clk) begin
        bit in_reg, exp_rdy;
        int per;
        logic [9:0] e;
        #3;
        per = wide_mode ? 2 : 5;
        in_reg = (eth_ptr <= SW'(LAST)) && (subch_idx >= eth_ptr);
        if (rst) begin
            chk(!tx_tready, "R1", "tready in reset", tx_tready, 0);
            chk(!rx_tvalid && !link_tx_valid, "R1", "valid in reset",
                rx_tvalid | link_tx_valid, 0);
            k = 0; prev_in = 0; prev_exp = 0; prev_acc = 0;
        end else begin
            if (in_reg) k = prev_in ? k + 1 : 0;
            else        k = 0;
            exp_rdy = in_reg && (k % per == 0);
            prev_in = in_reg;
            chk(tx_tready == exp_rdy, "R3", "tready vs slot model", tx_tready, exp_rdy);
            if (!in_reg)
                chk(!tx_tready, "R2", "tready outside region", tx_tready, 0);
            chk(link_tx_valid == prev_acc, "R4", "link valid after accept",
                link_tx_valid, prev_acc);
            if (prev_acc)
                chk({link_tx_data, link_tx_last, link_tx_err} == prev_byte, "R4",
                    "link byte", {link_tx_data, link_tx_last, link_tx_err}, prev_byte);
            if (rx_tvalid) begin
                chk(prev_exp, "R5", "rx strobe after slot", 0, 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "rx byte with empty queue", rx_tdata, -1);
                end else begin
                    e = exp_q.pop_front();
                    got++;
                    chk(rx_tdata == e[9:2], "R6", "rx data order", rx_tdata, e[9:2]);
                    chk(rx_tlast == e[1], "R6", "rx tlast", rx_tlast, e[1]);
                    chk(rx_tuser == e[0], "R7", "rx tuser", rx_tuser, e[0]);
                end
            end
            prev_acc  = tx_tvalid && tx_tready;
            prev_byte = {tx_tdata, tx_tlast, tx_tuser};
            prev_exp  = exp_rdy;
        end
    end

    task automatic apply_reset(input bit wm, input logic [SW-1:0] ptr);
        @(negedge clk);
        rst = 1'b1; tx_tvalid = 1'b0;
        wide_mode = wm; eth_ptr = ptr;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_frame(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tx_tdata  = 8'($urandom);
            tx_tlast  = (i == len - 1);
            tx_tuser  = ($urandom % 4 == 0);
            tx_tvalid = 1'b1;
            #1;
            while (!tx_tready) begin
                @(negedge clk);
                #1;
            end
            exp_q.push_back({tx_tdata, tx_tlast, tx_tuser});
            sent++;
        end
    endtask

    task automatic drain_and_check(input string name);
        @(negedge clk);
        tx_tvalid = 1'b0;
        repeat (300) @(negedge clk);
        chk(exp_q.size() == 0, "R6", {name, ": all bytes delivered"}, exp_q.size(), 0);
        chk(got == sent, "R6", {name, ": delivered count"}, got, sent);
    endtask

    // R3/R4/R6/R7: narrow mode, partial region, back-to-back random frames
    task automatic t_narrow_frames();
        apply_reset(1'b0, 4'd8);
        for (int f = 0; f < 6; f++) send_frame(1 + int'($urandom % 12));
        drain_and_check("narrow");
    endtask

    // R3/R5/R6: wide mode, region starting mid frame
    task automatic t_wide_frames();
        apply_reset(1'b1, 4'd5);
        for (int f = 0; f < 8; f++) send_frame(1 + int'($urandom % 16));
        drain_and_check("wide");
    endtask

    // R2/R3: pointer zero, region is the whole frame; single-byte frames
    task automatic t_full_region();
        apply_reset(1'b0, 4'd0);
        for (int f = 0; f < 5; f++) send_frame(1);
        send_frame(20);
        drain_and_check("full region");
    endtask

    // R2: pointer at the last subchannel, smallest region
    task automatic t_last_only();
        apply_reset(1'b1, 4'(LAST));
        send_frame(9);
        drain_and_check("last only");
    endtask

    // R8: pointer beyond last subchannel disables the channel
    task automatic t_disabled();
        int seen = 0;
        apply_reset(1'b0, 4'd13);
        @(negedge clk);
        tx_tvalid = 1'b1; tx_tdata = 8'h5A; tx_tlast = 1'b1;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            #1;
            if (tx_tready) seen++;
        end
        tx_tvalid = 1'b0;
        chk(seen == 0, "R8", "tready count while disabled", seen, 0);
        chk(exp_q.size() == 0 && got == sent, "R8", "no bytes moved while disabled",
            got, sent);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!tx_tready && !rx_tvalid && !link_tx_valid, "R1", "reset state", tx_tready, 0);
        t_narrow_frames();
        t_wide_frames();
        t_full_region();
        t_last_only();
        t_disabled();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule